// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Capture

This block is a memory-mapped controller for one bank of up to 32 general-purpose pads. Software writes the pad output values and the pad directions, reads the sampled pad inputs, and configures each pin as an interrupt source. Every register holds one bit per pin. Pin N always maps to bit N.

Each pin's interrupt is shaped by three independent configuration bits: one picks level or edge sensing, one picks the active polarity, and one makes an edge-sensed pin fire on both edges. Detected events are latched as per-pin pending flags. Software clears a flag by writing a 1 to its bit. A per-pin enable gates each flag onto one combined interrupt line for a parent controller. Output data, direction and interrupt enable also have write-1-to-set and write-1-to-clear alias addresses, so software never needs a read-modify-write sequence. The bus has no wait states. Writes take effect at the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, every pin is an input (pad_oe = 0), and irq is 0.
- R2: Direction is read and written at 0x08, where bit = 1 makes the pin an output and drives pad_oe. Writing 1s at 0x48 sets direction bits. Writing 1s at 0x4C clears them. Zero bits at either alias leave the pin unchanged.
- R3: Output data is read and written at 0x00 and drives pad_out. Writing 1s at 0x40 forces bits to 1. Writing 1s at 0x44 forces bits to 0. Zero bits have no effect.
- R4: Reading 0x04 returns the pad inputs after a two-flop synchronizer. A pad change becomes visible two clock edges after it is applied, and not after one.
- R5: The six alias addresses 0x30, 0x34, 0x40, 0x44, 0x48 and 0x4C read back as 0.
- R6: A pin with configuration bit 0 at 0x2C (edge sensing) and polarity bit 0 at 0x18 captures a rising edge and ignores a falling edge. The capture flag is set three clock edges after the pad change.
- R7: An edge-sensed pin with polarity bit 1 at 0x18 captures a falling edge and ignores a rising edge.
- R8: An edge-sensed pin with its bit set at 0x1C captures both edges, whatever its polarity bit says.
- R9: A pin with bit 1 at 0x2C is level-sensed: high is active when its polarity bit is 0, and low is active when it is 1. The flag is set again on every cycle the active level is present.
- R10: The capture register at 0x20 reads the pending flags. Writing 1s clears the matching flags. If an event arrives in the same cycle as the clear, the event wins, so the flag of a level-sensed pin stays set while its level is active.
- R11: Writing 1s at 0x30 enables the matching pins and writing 1s at 0x34 disables them. irq is the OR of the pending flags that are enabled, and it changes in the same cycle as the flag or the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPIN (32) | Asynchronous pad inputs |
| pad_out | output | NPIN (32) | Output data to the pads |
| pad_oe | output | NPIN (32) | Pad output enables (1 = drive) |
| irq | output | 1 | Combined interrupt to the parent controller |

## Verification
Register writes, alias effects and enable changes show on the ports right after the edge that takes the write. A pad change reaches the input register after two edges and the capture flag after three. Irq follows the flag with no further delay. The bench drives stimulus between edges and counts those edges explicitly before it queues an expected value. A monitor then compares that value at the next falling edge. The input register is also read one edge early, to confirm that the synchronizer latency is exactly two.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets and shared constants for the GPIO bank.
// Assumes byte addressing with one 32-bit word per register.
package gpio_bank_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_OUT    = 8'h00;
    localparam logic [7:0] OFS_IN     = 8'h04;
    localparam logic [7:0] OFS_DIR    = 8'h08;
    localparam logic [7:0] OFS_POL    = 8'h18;
    localparam logic [7:0] OFS_BOTH   = 8'h1C;
    localparam logic [7:0] OFS_CAP    = 8'h20;
    localparam logic [7:0] OFS_LVL    = 8'h2C;
    localparam logic [7:0] OFS_ENSET  = 8'h30;
    localparam logic [7:0] OFS_ENCLR  = 8'h34;
    localparam logic [7:0] OFS_OUTSET = 8'h40;
    localparam logic [7:0] OFS_OUTCLR = 8'h44;
    localparam logic [7:0] OFS_DIRSET = 8'h48;
    localparam logic [7:0] OFS_DIRCLR = 8'h4C;

    // Decoded write target, one-hot in practice
    typedef enum logic [3:0] {
        WT_NONE, WT_OUT, WT_DIR, WT_POL, WT_BOTH, WT_CAP, WT_LVL,
        WT_ENSET, WT_ENCLR, WT_OUTSET, WT_OUTCLR, WT_DIRSET, WT_DIRCLR
    } wr_tgt_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence is promised across bits.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pads
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
// Module: per-pin event detection (edge or level, polarity, both-edge override).
// Assumes s is already synchronous; keeps one cycle of history for edges.
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s,
    input  logic [W-1:0] lvl_sel,
    input  logic [W-1:0] neg_sel,
    input  logic [W-1:0] both_sel,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    // History of the synchronized inputs for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= s;
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        // Per-pin event decode
        always_comb begin
            rise     = s[p] & ~prev_q[p];
            fall     = ~s[p] & prev_q[p];
            lvl_hit  = neg_sel[p] ? ~s[p] : s[p];
            edge_hit = both_sel[p] ? (rise | fall)
                                   : (neg_sel[p] ? fall : rise);
            evt[p]   = lvl_sel[p] ? lvl_hit : edge_hit;
        end
    end
endmodule

// File: rtl/gpio_cap_mask.sv
// Module: pending-flag capture, interrupt enables and combined interrupt.
// Assumes a new event outranks a write-1-to-clear in the same cycle.
module gpio_cap_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         cap_clr_wr,
    input  logic         en_set_wr,
    input  logic         en_clr_wr,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] cap_q,
    output logic [W-1:0] en_q,
    output logic         irq
);
    // Pending flags: clear by mask, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~(cap_clr_wr ? wmask : '0)) | evt;
    end

    // Enables via set/clear aliases only
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (en_set_wr) en_q <= en_q | wmask;
        else if (en_clr_wr) en_q <= en_q & ~wmask;
    end

    assign irq = |(cap_q & en_q);
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: top of the GPIO bank; register file, write decode and read mux.
// Assumes NPIN <= 32 and a zero-wait-state bus with combinational reads.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    logic [NPIN-1:0] wmask, in_s, evt, cap_q, en_q;
    logic [NPIN-1:0] out_q, dir_q, pol_q, both_q, lvl_q;
    wr_tgt_e         tgt;

    assign wmask = bus_wdata[NPIN-1:0];

    // Decode the address into a write target
    always_comb begin
        tgt = WT_NONE;
        if (bus_we) begin
            case (bus_addr)
                AW'(OFS_OUT):    tgt = WT_OUT;
                AW'(OFS_DIR):    tgt = WT_DIR;
                AW'(OFS_POL):    tgt = WT_POL;
                AW'(OFS_BOTH):   tgt = WT_BOTH;
                AW'(OFS_CAP):    tgt = WT_CAP;
                AW'(OFS_LVL):    tgt = WT_LVL;
                AW'(OFS_ENSET):  tgt = WT_ENSET;
                AW'(OFS_ENCLR):  tgt = WT_ENCLR;
                AW'(OFS_OUTSET): tgt = WT_OUTSET;
                AW'(OFS_OUTCLR): tgt = WT_OUTCLR;
                AW'(OFS_DIRSET): tgt = WT_DIRSET;
                AW'(OFS_DIRCLR): tgt = WT_DIRCLR;
                default:         tgt = WT_NONE;
            endcase
        end
    end

    // Output data with direct, set and clear access
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else case (tgt)
            WT_OUT:    out_q <= wmask;
            WT_OUTSET: out_q <= out_q | wmask;
            WT_OUTCLR: out_q <= out_q & ~wmask;
            default:   out_q <= out_q;
        endcase
    end

    // Direction with direct, set and clear access
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else case (tgt)
            WT_DIR:    dir_q <= wmask;
            WT_DIRSET: dir_q <= dir_q | wmask;
            WT_DIRCLR: dir_q <= dir_q & ~wmask;
            default:   dir_q <= dir_q;
        endcase
    end

    // Interrupt shaping configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            both_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (tgt == WT_POL)  pol_q  <= wmask;
            if (tgt == WT_BOTH) both_q <= wmask;
            if (tgt == WT_LVL)  lvl_q  <= wmask;
        end
    end

    gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_s)
    );

    gpio_evt_detect #(.W(NPIN)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .s        (in_s),
        .lvl_sel  (lvl_q),
        .neg_sel  (pol_q),
        .both_sel (both_q),
        .evt      (evt)
    );

    gpio_cap_mask #(.W(NPIN)) u_capmask (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .cap_clr_wr (tgt == WT_CAP),
        .en_set_wr  (tgt == WT_ENSET),
        .en_clr_wr  (tgt == WT_ENCLR),
        .wmask      (wmask),
        .cap_q      (cap_q),
        .en_q       (en_q),
        .irq        (irq)
    );

    // Read mux; aliases and unmapped addresses return zero
    always_comb begin
        case (bus_addr)
            AW'(OFS_OUT):  bus_rdata = 32'(out_q);
            AW'(OFS_IN):   bus_rdata = 32'(in_s);
            AW'(OFS_DIR):  bus_rdata = 32'(dir_q);
            AW'(OFS_POL):  bus_rdata = 32'(pol_q);
            AW'(OFS_BOTH): bus_rdata = 32'(both_q);
            AW'(OFS_CAP):  bus_rdata = 32'(cap_q);
            AW'(OFS_LVL):  bus_rdata = 32'(lvl_q);
            default:       bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Checker: temporal properties of the GPIO bank, bound to the top module.
// Assumes default register offsets from the package.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_we,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] en_q,
    input logic            irq
);
    logic alias_addr;
    assign alias_addr = (bus_addr == AW'(OFS_ENSET))  || (bus_addr == AW'(OFS_ENCLR))  ||
                        (bus_addr == AW'(OFS_OUTSET)) || (bus_addr == AW'(OFS_OUTCLR)) ||
                        (bus_addr == AW'(OFS_DIRSET)) || (bus_addr == AW'(OFS_DIRCLR));

    a_r5_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        alias_addr |-> bus_rdata == 32'd0);

    a_r2_dirset_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_DIRSET)) |=>
        pad_oe == ($past(pad_oe) | $past(bus_wdata[NPIN-1:0])));

    a_r3_outclr_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_OUTCLR)) |=>
        pad_out == ($past(pad_out) & ~$past(bus_wdata[NPIN-1:0])));

    a_r11_enclr_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_ENCLR)) |=>
        en_q == ($past(en_q) & ~$past(bus_wdata[NPIN-1:0])));

    a_r11_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/gpio_irq_bank_bench.sv
// Bench: scoreboard-style checks of the GPIO bank through its ports.
module gpio_irq_bank_bench;
    localparam int NPIN = 32;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe;
    logic            irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;  // 0 rdata, 1 irq, 2 pad_out, 3 pad_oe
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    gpio_irq_bank #(.NPIN(NPIN), .AW(AW)) u_gpio_irq_bank (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .pad_in, .pad_out, .pad_oe, .irq
    );

    // Monitor: pop queued expectations and compare at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {31'd0, irq};
                2: act = pad_out;
                default: act = pad_oe;
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic expect_v(input int kind, input logic [7:0] a,
                            input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        expect_v(0, 8'h00, 32'h0, "R1 out");
        expect_v(0, 8'h08, 32'h0, "R1 dir");
        expect_v(0, 8'h20, 32'h0, "R1 cap");
        expect_v(3, 8'h00, 32'h0, "R1 pad_oe");
        expect_v(1, 8'h00, 32'h0, "R1 irq");

        // R3: output direct, set, clear
        wr(8'h00, 32'h0000_00A5);
        expect_v(2, 8'h00, 32'h0000_00A5, "R3 direct pad_out");
        expect_v(0, 8'h00, 32'h0000_00A5, "R3 readback");
        wr(8'h40, 32'h0000_0100);
        expect_v(2, 8'h00, 32'h0000_01A5, "R3 set");
        wr(8'h44, 32'h0000_0005);
        expect_v(2, 8'h00, 32'h0000_01A0, "R3 clear");

        // R2: direction direct, set, clear
        wr(8'h08, 32'h0000_00F0);
        expect_v(3, 8'h00, 32'h0000_00F0, "R2 direct");
        wr(8'h48, 32'h0000_0001);
        expect_v(3, 8'h00, 32'h0000_00F1, "R2 set");
        wr(8'h4C, 32'h0000_0030);
        expect_v(0, 8'h08, 32'h0000_00C1, "R2 clear readback");

        // R5: aliases read zero
        expect_v(0, 8'h30, 32'h0, "R5 0x30");
        expect_v(0, 8'h34, 32'h0, "R5 0x34");
        expect_v(0, 8'h40, 32'h0, "R5 0x40");
        expect_v(0, 8'h44, 32'h0, "R5 0x44");
        expect_v(0, 8'h48, 32'h0, "R5 0x48");
        expect_v(0, 8'h4C, 32'h0, "R5 0x4C");

        // R4: two-edge input latency
        pad_in = 32'h0000_0F00;
        tick();
        expect_v(0, 8'h04, 32'h0, "R4 not after one edge");
        tick();
        expect_v(0, 8'h04, 32'h0000_0F00, "R4 after two edges");
        tick(); tick();
        wr(8'h20, 32'hFFFF_FFFF);
        expect_v(0, 8'h20, 32'h0, "R10 clear all");

        // R6: rising edge on pin 0, masked
        pad_in[0] = 1'b1;
        repeat (3) tick();
        expect_v(0, 8'h20, 32'h0000_0001, "R6 rise captured");
        expect_v(1, 8'h00, 32'h0, "R11 masked irq low");
        wr(8'h30, 32'h0000_0001);
        expect_v(1, 8'h00, 32'h1, "R11 enabled irq high");
        wr(8'h20, 32'h0000_0001);
        expect_v(0, 8'h20, 32'h0, "R10 edge flag cleared");
        expect_v(1, 8'h00, 32'h0, "R11 irq drops");
        pad_in[0] = 1'b0;
        repeat (4) tick();
        expect_v(0, 8'h20, 32'h0, "R6 fall ignored");

        // R7: falling edge on pin 1
        wr(8'h18, 32'h0000_0002);
        pad_in[1] = 1'b1;
        repeat (4) tick();
        expect_v(0, 8'h20, 32'h0, "R7 rise ignored");
        pad_in[1] = 1'b0;
        repeat (3) tick();
        expect_v(0, 8'h20, 32'h0000_0002, "R7 fall captured");
        wr(8'h20, 32'hFFFF_FFFF);

        // R8: both edges on pin 2 (polarity negative too)
        wr(8'h1C, 32'h0000_0004);
        wr(8'h18, 32'h0000_0006);
        pad_in[2] = 1'b1;
        repeat (3) tick();
        expect_v(0, 8'h20, 32'h0000_0004, "R8 rise captured");
        wr(8'h20, 32'h0000_0004);
        pad_in[2] = 1'b0;
        repeat (3) tick();
        expect_v(0, 8'h20, 32'h0000_0004, "R8 fall captured");
        wr(8'h20, 32'hFFFF_FFFF);
        expect_v(0, 8'h20, 32'h0, "R10 clear before level");

        // R9, R10: level high on pin 3
        wr(8'h2C, 32'h0000_0008);
        pad_in[3] = 1'b1;
        repeat (3) tick();
        expect_v(0, 8'h20, 32'h0000_0008, "R9 high level captured");
        wr(8'h20, 32'h0000_0008);
        expect_v(0, 8'h20, 32'h0000_0008, "R10 event wins over clear");
        wr(8'h30, 32'h0000_0008);
        expect_v(1, 8'h00, 32'h1, "R11 level irq");
        wr(8'h34, 32'h0000_0008);
        expect_v(1, 8'h00, 32'h0, "R11 disabled irq low");
        pad_in[3] = 1'b0;
        repeat (3) tick();
        wr(8'h20, 32'h0000_0008);
        expect_v(0, 8'h20, 32'h0, "R9 clear after level gone");

        // R9: level low on pin 4
        wr(8'h18, 32'h0000_0016);
        expect_v(0, 8'h20, 32'h0, "R9 negative edge idle");
        wr(8'h2C, 32'h0000_0018);
        tick();
        expect_v(0, 8'h20, 32'h0000_0010, "R9 low level captured");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule